// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Controller

This block generates all refresh traffic for a two-bank asynchronous DRAM array. After reset it waits out a power-up pause and then runs a fixed number of warm-up refresh cycles. Once those are done it raises `ready_o`, which tells the access sequencer that normal reads and writes may begin. From then on an interval timer asks for one distributed refresh every `INTERVAL_CYC` clock cycles.

Every refresh is a column-before-row cycle. The column strobes fall first and the row strobes follow. The device takes the row from its own internal counter, so the block drives no address. Both banks' row strobes move together. Write enable is held high.

The block shares the strobes with an access sequencer through a request/grant pair. It raises `req_o` when refresh work is owed. It starts a cycle only when `grant_i` is sampled high while it is idle, and it owns the strobes until that cycle completes. Refreshes that cannot be issued build up in a saturating pending count. When the grant comes, they are issued back to back: the column strobes stay low and only the row strobes toggle.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is held, all row and column strobes are high (inactive), and `req_o`, `ready_o` and `urgent_o` are 0.
- R2: `req_o` stays 0 for the first `PAUSE_CYC` - 1 clock edges after reset is released. It is 1 after edge `PAUSE_CYC`. No strobe moves during the pause.
- R3: Exactly `WARMUP_N` refresh cycles complete before `ready_o` rises. With the grant held, the column strobes rise exactly once in the warm-up, at the end. `ready_o` rises on that same edge and never falls afterwards.
- R4: Every run of refreshes starts with the column strobes low for exactly `CAS_LEAD_CYC` cycles before the row strobes fall. The column strobes are low in every cycle in which a row strobe is low.
- R5: Each row strobe low pulse lasts exactly `RAS_LOW_CYC` cycles. Between chained refreshes the row strobes are high for exactly `RAS_PRE_CYC` cycles while the column strobes stay low.
- R6: Both row strobe bits are always equal, all four column strobe bits are always equal, and `we_n_o` is always 1.
- R7: After `ready_o`, one refresh falls due every `INTERVAL_CYC` cycles. The first one is due on edge `INTERVAL_CYC` after the `ready_o` edge, and `req_o` becomes 1 on that edge. `req_o` is 0 whenever no refresh is owed and none is in progress. While `req_o` is 0 the strobes are all high. With the grant held, each due refresh is issued as a single cycle.
- R8: The pending count saturates at `PEND_MAX`, and further due refreshes are dropped. `urgent_o` is 1 exactly while the count is at `PEND_MAX`. It rises on the edge on which the `PEND_MAX`-th due refresh arrives.
- R9: When more than one refresh is owed and the grant stays high, the refreshes chain. Their number equals the pending count, and the column strobes rise only once, after the last of them.
- R10: A refresh cycle starts only if `grant_i` was 1 on the edge on which it leaves idle. While the grant is withheld, no strobe moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grant_i | input | 1 | Strobe ownership granted by the access sequencer |
| req_o | output | 1 | Refresh work owed or in progress |
| urgent_o | output | 1 | Pending count at its maximum |
| ready_o | output | 1 | Initialisation complete, normal access allowed |
| ras_n_o | output | 2 | Row strobes, one per bank, active low |
| cas_n_o | output | 4 | Column strobes, one per byte lane, active low |
| we_n_o | output | 1 | Write enable, active low, held high |

## Verification
The bench runs a small configuration: a 20-cycle pause, an interval of 40 cycles and a pending limit of 4. It drives the main function with three grant patterns. First, the grant is held through the warm-up, which must give a single chain of exactly eight refreshes. Second, the grant is withheld for more than `PEND_MAX` intervals and then given, which separates a saturating count from a wrapping or unbounded one by the length of the resulting burst. Third, the grant is held continuously while single interval refreshes arrive, which shows that one due refresh gives one isolated cycle. A per-cycle monitor measures the lead, low and precharge widths of every strobe pulse against the parameters. The same monitor counts row falls and column rises, and these counts separate chained cycles from separate ones.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_LEAD, SEQ_LOW, SEQ_PRE} seq_state_e;
  typedef enum logic [1:0] {PH_PAUSE, PH_WARM, PH_RUN} init_phase_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/rfc_init_ctrl.sv
module rfc_init_ctrl
  import rfc_pkg::*;
#(
  parameter int PAUSE_CYC = 25000,
  parameter int WARMUP_N  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  output logic ready_o,
  output logic warm_need_o,
  output logic warm_more_o
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int WW = $clog2(WARMUP_N + 1);

  init_phase_e     phase_q;
  logic [PW-1:0]   pause_q;
  logic [WW-1:0]   warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_PAUSE;
      pause_q <= '0;
      warm_q  <= WW'(WARMUP_N);
    end else begin
      unique case (phase_q)
        PH_PAUSE: begin
          if (pause_q == PW'(PAUSE_CYC - 1)) phase_q <= PH_WARM;
          else                               pause_q <= pause_q + 1'b1;
        end
        PH_WARM: begin
          if (done_i) begin
            warm_q <= warm_q - 1'b1;
            if (warm_q == WW'(1)) phase_q <= PH_RUN;
          end
        end
        default: ;
      endcase
    end
  end

  assign ready_o     = (phase_q == PH_RUN);
  assign warm_need_o = (phase_q == PH_WARM);
  assign warm_more_o = (phase_q == PH_WARM) && (warm_q > WW'(1));
endmodule

// File: rtl/rfc_interval.sv
module rfc_interval #(
  parameter int INTERVAL_CYC = 1950
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int IW = $clog2(INTERVAL_CYC);

  logic [IW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == IW'(INTERVAL_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rfc_pending.sv
module rfc_pending #(
  parameter int PEND_MAX = 8,
  localparam int PCW     = $clog2(PEND_MAX + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           dec_i,
  output logic [PCW-1:0] cnt_o,
  output logic           full_o
);
  logic [PCW-1:0] cnt_q;
  logic inc, dec;

  assign full_o = (cnt_q == PCW'(PEND_MAX));
  assign inc    = tick_i && !full_o;
  assign dec    = dec_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      unique case ({inc, dec})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rfc_cbr_seq.sv
module rfc_cbr_seq
  import rfc_pkg::*;
#(
  parameter int CAS_LEAD_CYC = 1,
  parameter int RAS_LOW_CYC  = 8,
  parameter int RAS_PRE_CYC  = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic need_i,
  input  logic more_i,
  input  logic grant_i,
  output logic busy_o,
  output logic done_o,
  output logic ras_act_o,
  output logic cas_act_o
);
  localparam int CW = $clog2(max3(CAS_LEAD_CYC, RAS_LOW_CYC, RAS_PRE_CYC) + 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, lim;
  logic          last;

  always_comb begin
    unique case (state_q)
      SEQ_LEAD: lim = CW'(CAS_LEAD_CYC - 1);
      SEQ_LOW:  lim = CW'(RAS_LOW_CYC - 1);
      SEQ_PRE:  lim = CW'(RAS_PRE_CYC - 1);
      default:  lim = '0;
    endcase
  end

  assign last   = (cnt_q == lim);
  assign done_o = (state_q == SEQ_PRE) && last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (need_i && grant_i) state_d = SEQ_LEAD;
      SEQ_LEAD: if (last) state_d = SEQ_LOW;
      SEQ_LOW:  if (last) state_d = SEQ_PRE;
      SEQ_PRE:  if (last) state_d = (more_i && grant_i) ? SEQ_LOW : SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
    end
  end

  assign busy_o    = (state_q != SEQ_IDLE);
  assign cas_act_o = busy_o;
  assign ras_act_o = (state_q == SEQ_LOW);
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int PAUSE_CYC    = 25000,
  parameter int WARMUP_N     = 8,
  parameter int INTERVAL_CYC = 1950,
  parameter int PEND_MAX     = 8,
  parameter int CAS_LEAD_CYC = 1,
  parameter int RAS_LOW_CYC  = 8,
  parameter int RAS_PRE_CYC  = 5,
  parameter int NUM_BANKS    = 2,
  parameter int NUM_LANES    = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 grant_i,
  output logic                 req_o,
  output logic                 urgent_o,
  output logic                 ready_o,
  output logic [NUM_BANKS-1:0] ras_n_o,
  output logic [NUM_LANES-1:0] cas_n_o,
  output logic                 we_n_o
);
  localparam int PCW = $clog2(PEND_MAX + 1);

  logic           done, busy, ras_act, cas_act, tick;
  logic           warm_need, warm_more, need, more;
  logic [PCW-1:0] pend_cnt;

  rfc_init_ctrl #(.PAUSE_CYC(PAUSE_CYC), .WARMUP_N(WARMUP_N)) u_init (
    .clk_i, .rst_ni, .done_i(done), .ready_o,
    .warm_need_o(warm_need), .warm_more_o(warm_more)
  );

  rfc_interval #(.INTERVAL_CYC(INTERVAL_CYC)) u_ivl (
    .clk_i, .rst_ni, .en_i(ready_o), .tick_o(tick)
  );

  rfc_pending #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk_i, .rst_ni, .tick_i(tick), .dec_i(done && ready_o),
    .cnt_o(pend_cnt), .full_o(urgent_o)
  );

  // chain only when a further refresh remains after the one now finishing
  assign need = warm_need || (pend_cnt != '0);
  assign more = warm_more || (pend_cnt > PCW'(1));

  rfc_cbr_seq #(
    .CAS_LEAD_CYC(CAS_LEAD_CYC), .RAS_LOW_CYC(RAS_LOW_CYC), .RAS_PRE_CYC(RAS_PRE_CYC)
  ) u_seq (
    .clk_i, .rst_ni, .need_i(need), .more_i(more), .grant_i,
    .busy_o(busy), .done_o(done), .ras_act_o(ras_act), .cas_act_o(cas_act)
  );

  assign req_o  = need || busy;
  assign we_n_o = 1'b1;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_ras
    assign ras_n_o[b] = ~ras_act;
  end
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_cas
    assign cas_n_o[l] = ~cas_act;
  end
endmodule

// File: rtl/rfc_chk.sv
module rfc_chk #(
  parameter int NUM_BANKS = 2,
  parameter int NUM_LANES = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 grant_i,
  input logic                 req_o,
  input logic                 urgent_o,
  input logic                 ready_o,
  input logic [NUM_BANKS-1:0] ras_n_o,
  input logic [NUM_LANES-1:0] cas_n_o
);
  // R4
  cas_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o[0]) |-> (cas_n_o == '0) && $past(cas_n_o == '0));

  // R4
  cas_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o[0] |-> (cas_n_o == '0));

  // R10
  grant_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_o[0]) |-> $past(grant_i));

  // R8
  urgent_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urgent_o |-> req_o);

  // R3
  ready_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  // R7
  quiet_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> (&ras_n_o) && (&cas_n_o));
endmodule

bind dram_refresh_ctrl rfc_chk #(.NUM_BANKS(NUM_BANKS), .NUM_LANES(NUM_LANES)) u_rfc_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .grant_i(grant_i), .req_o(req_o),
  .urgent_o(urgent_o), .ready_o(ready_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o)
);

// File: tb/dram_refresh_ctrl_bench.sv
module dram_refresh_ctrl_bench;
  localparam int PAUSE = 20, WARM = 8, IVL = 40, PMAX = 4;
  localparam int LEAD = 1, RLOW = 3, RPRE = 2;

  logic clk = 1'b0, rst_n = 1'b0, grant = 1'b0;
  logic req, urgent, ready, we_n;
  logic [1:0] ras_n;
  logic [3:0] cas_n;

  always #4 clk = ~clk;

  dram_refresh_ctrl #(
    .PAUSE_CYC(PAUSE), .WARMUP_N(WARM), .INTERVAL_CYC(IVL), .PEND_MAX(PMAX),
    .CAS_LEAD_CYC(LEAD), .RAS_LOW_CYC(RLOW), .RAS_PRE_CYC(RPRE)
  ) u_dram_refresh_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .grant_i(grant), .req_o(req), .urgent_o(urgent),
    .ready_o(ready), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n)
  );

  int checks = 0, errors = 0;
  int ras_falls = 0, cas_rises = 0;
  int low_len = 0, pre_len = 0, lead_len = 0;
  bit seen_ras = 0, fin = 0;
  logic pr_ras = 1'b1, pr_cas = 1'b1;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", r, act, exp);
    end
  endtask

  // per-cycle strobe monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (ras_n != {2{ras_n[0]}} || cas_n != {4{cas_n[0]}} || we_n !== 1'b1)
        chk(0, "R6 strobe bits differ", {25'd0, we_n, ras_n, cas_n}, 32'h7f);
      if (!ras_n[0] && cas_n[0]) chk(0, "R4 row low with column high", 1, 0);
      if (pr_ras && !ras_n[0]) begin
        ras_falls++;
        if (!seen_ras) chk(lead_len == LEAD, "R4 column lead", lead_len, LEAD);
        else           chk(pre_len == RPRE, "R5 chained precharge", pre_len, RPRE);
        seen_ras = 1; pre_len = 0; low_len = 0;
      end
      if (!pr_ras && ras_n[0]) begin
        chk(low_len == RLOW, "R5 row low width", low_len, RLOW);
        pre_len = 0;
      end
      if (!pr_cas && cas_n[0]) begin
        cas_rises++; seen_ras = 0; lead_len = 0; pre_len = 0;
      end
      if (pr_cas && !cas_n[0]) lead_len = 0;
      if (!ras_n[0]) low_len++;
      if (!cas_n[0] && ras_n[0]) begin
        if (!seen_ras) lead_len++;
        else           pre_len++;
      end
      pr_ras = ras_n[0];
      pr_cas = cas_n[0];
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk); #1;
  endtask

  task automatic finish_run;
    fin = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      finish_run();
    end
  end

  initial begin
    int f0, c0, n;
    repeat (3) @(negedge clk); #1;
    // R1
    chk(ras_n == 2'b11 && cas_n == 4'hf, "R1 strobes in reset", {ras_n, cas_n}, 8'h3f);
    chk(!req && !ready && !urgent, "R1 flags in reset", {req, ready, urgent}, 0);
    @(negedge clk); rst_n = 1'b1;
    step(PAUSE - 1);
    chk(req == 1'b0, "R2 request during pause", req, 0);
    step(1);
    chk(req == 1'b1, "R2 request after pause", req, 1);
    chk(ras_falls == 0 && cas_rises == 0, "R2 no strobes in pause", ras_falls, 0);
    grant = 1'b1;
    n = 0;
    while (!ready && n < 500) begin step(1); n++; end
    chk(ras_falls == WARM, "R3 warm-up refresh count", ras_falls, WARM);
    chk(cas_rises == 1, "R3 warm-up chained", cas_rises, 1);
    grant = 1'b0;
    step(IVL - 1);
    chk(req == 1'b0, "R7 no request before first interval", req, 0);
    step(1);
    chk(req == 1'b1, "R7 request at first interval", req, 1);
    step(3 * IVL - 1);
    chk(urgent == 1'b0, "R8 urgent below max", urgent, 0);
    step(1);
    chk(urgent == 1'b1, "R8 urgent at max", urgent, 1);
    step(90);
    chk(urgent == 1'b1, "R8 urgent held while saturated", urgent, 1);
    chk(ras_falls == WARM, "R10 no refresh without grant", ras_falls, WARM);
    f0 = ras_falls; c0 = cas_rises;
    grant = 1'b1;
    n = 0;
    step(1);
    while (req && n < 500) begin step(1); n++; end
    chk(ras_falls - f0 == PMAX, "R8 burst limited to saturated count", ras_falls - f0, PMAX);
    chk(cas_rises - c0 == 1, "R9 burst chained with column low", cas_rises - c0, 1);
    chk(urgent == 1'b0, "R8 urgent cleared after burst", urgent, 0);
    f0 = ras_falls; c0 = cas_rises;
    step(2 * IVL);
    chk(ras_falls - f0 == 2, "R7 one refresh per interval", ras_falls - f0, 2);
    chk(cas_rises - c0 == 2, "R7 single refreshes not chained", cas_rises - c0, 2);
    chk(ready == 1'b1, "R3 ready stays high", ready, 1);
    finish_run();
  end
endmodule